// File: doc/BRIEF.md
# Circular-Stack Floating-Point Register File

This block holds eight extended-precision floating-point registers and addresses them as a circular stack. A three-bit top pointer names the physical slot that currently plays the role of the stack top; every other register is reached by adding a small offset to that pointer, with the sum wrapping modulo eight. As a result, the physical slot behind a given logical register moves each time a value is pushed or popped.

Each slot holds three fields that travel on buses of their own: a two-bit tag, a 16-bit sign-and-exponent field and a 64-bit fraction. A datapath drives one command per cycle. A push moves the pointer down and stores a value in the new top. A pop presents the top and moves the pointer up. An offset read presents any slot relative to the top, and an offset write stores into any slot relative to the top. Reads are combinational from the current pointer. Pointer and storage updates land at the next rising clock edge.

Top module: `fp_stack_rf`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the pointer to 0, sets every tag to 2'b11 (empty), and clears every exponent and fraction to zero.
- R2: `cmd_i` is decoded as follows: 3'd0 idle, 3'd1 push, 3'd2 pop, 3'd3 offset read, 3'd4 offset write. Codes 5 to 7 act as idle. An idle cycle changes neither the pointer nor any slot.
- R3: A push decrements the pointer modulo eight. It then writes `tag_i`, `exp_i` and `frac_i` into the slot named by the decremented pointer, which becomes the new top.
- R4: During a pop cycle the read buses show the current top slot. At the next edge the pointer increments modulo eight, and no slot contents change.
- R5: During an offset read the read buses show, combinationally, slot (pointer + `ofs_i`) mod 8. The pointer does not change.
- R6: An offset write stores the three input fields into slot (pointer + `ofs_i`) mod 8. The pointer and all other slots are left unchanged.
- R7: The pointer and the offset sum wrap. A push at pointer 0 gives pointer 7, a pop at pointer 7 gives pointer 0, and offset 7 from pointer 2 selects physical slot 1.
- R8: In every cycle that is not an offset read, the read buses show the slot named by the current pointer. `top_o` always shows the current pointer.
- R9: The tag, exponent and fraction fields are stored and returned bit-exactly and independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Command code |
| ofs_i | input | 3 | Offset from the top for offset read and offset write |
| tag_i | input | 2 | Tag field to store |
| exp_i | input | 16 | Sign-and-exponent field to store |
| frac_i | input | 64 | Fraction field to store |
| tag_o | output | 2 | Tag of the selected slot |
| exp_o | output | 16 | Sign-and-exponent of the selected slot |
| frac_o | output | 64 | Fraction of the selected slot |
| top_o | output | 3 | Current top pointer |

## Verification
The stack is first filled with nine pushes so that the pointer passes through zero and wraps, and each push stores a distinct bit pattern in every field. A fault in the decrement direction, the write decode or a field lane therefore shows up as a wrong value at a specific slot. Offset reads are then swept across all eight offsets from more than one pointer position. This separates a correct modulo-eight sum from a fixed index or a sum that saturates instead of wrapping, and the case of offset 7 from pointer 2 is checked directly. Pops, offset writes, idle cycles and the unused codes are interleaved with reads of neighbouring slots. This shows which commands move the pointer and which slots each command leaves untouched.

// File: rtl/fp_stack_rf.sv
module fp_stack_rf #(
  parameter int DEPTH = 8,
  parameter int TW    = 2,
  parameter int EW    = 16,
  parameter int FW    = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               cmd_i,
  input  logic [$clog2(DEPTH)-1:0] ofs_i,
  input  logic [TW-1:0]            tag_i,
  input  logic [EW-1:0]            exp_i,
  input  logic [FW-1:0]            frac_i,
  output logic [TW-1:0]            tag_o,
  output logic [EW-1:0]            exp_o,
  output logic [FW-1:0]            frac_o,
  output logic [$clog2(DEPTH)-1:0] top_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [2:0] C_PUSH = 3'd1, C_POP = 3'd2, C_RD = 3'd3, C_WR = 3'd4;

  logic [AW-1:0] top_q, sum, rd_addr, wr_addr;
  logic [TW-1:0] tag_q  [DEPTH];
  logic [EW-1:0] exp_q  [DEPTH];
  logic [FW-1:0] frac_q [DEPTH];
  logic [DEPTH-1:0] wsel;
  logic wr_en;

  assign sum     = top_q + ofs_i;
  assign rd_addr = (cmd_i == C_RD) ? sum : top_q;
  assign wr_addr = (cmd_i == C_PUSH) ? top_q - 1'b1 : sum;
  assign wr_en   = (cmd_i == C_PUSH) || (cmd_i == C_WR);

  assign tag_o  = tag_q[rd_addr];
  assign exp_o  = exp_q[rd_addr];
  assign frac_o = frac_q[rd_addr];
  assign top_o  = top_q;

  always_ff @(posedge clk) begin
    if (rst)                    top_q <= '0;
    else if (cmd_i == C_PUSH)   top_q <= top_q - 1'b1;
    else if (cmd_i == C_POP)    top_q <= top_q + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign wsel[i] = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[i]  <= '1;
        exp_q[i]  <= '0;
        frac_q[i] <= '0;
      end else if (wsel[i]) begin
        tag_q[i]  <= tag_i;
        exp_q[i]  <= exp_i;
        frac_q[i] <= frac_i;
      end
    end
  end
endmodule

module fp_stack_rf_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd_i,
  input logic [2:0] top_o,
  input logic [1:0] tag_i,
  input logic [1:0] tag_o,
  input logic [7:0] wsel
);
  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_i == 3'd1 |=> top_o == 3'($past(top_o) - 3'd1));
  // R3
  push_tag_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_i == 3'd1 |=> (cmd_i == 3'd3) || (tag_o == $past(tag_i)));
  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_i == 3'd2 |=> top_o == 3'($past(top_o) + 3'd1));
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_i == 3'd3 |=> $stable(top_o));
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_i == 3'd4 |=> $stable(top_o));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd0 || cmd_i > 3'd4) |=> $stable(top_o));
  // R6
  one_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wsel));
endmodule

bind fp_stack_rf fp_stack_rf_chk u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .top_o(top_o),
  .tag_i(tag_i), .tag_o(tag_o), .wsel(wsel)
);

// File: tb/sim_fp_stack_rf.sv
module sim_fp_stack_rf;
  typedef struct {
    logic [1:0]  tag;
    logic [15:0] ex;
    logic [63:0] fr;
    logic [2:0]  top;
    string       req;
  } exp_t;

  logic clk = 0, rst = 1;
  logic [2:0] cmd = 0, ofs = 0;
  logic [1:0] tag_i = 0;
  logic [15:0] exp_i = 0;
  logic [63:0] frac_i = 0;
  logic [1:0] tag_o;
  logic [15:0] exp_o;
  logic [63:0] frac_o;
  logic [2:0] top_o;

  int compared = 0, mismatched = 0;
  bit done = 0;
  exp_t sb[$];

  logic [1:0]  mt [8];
  logic [15:0] me [8];
  logic [63:0] mf [8];
  logic [2:0]  mtop;

  always #4 clk = ~clk;

  fp_stack_rf u0 (.clk(clk), .rst(rst), .cmd_i(cmd), .ofs_i(ofs), .tag_i(tag_i),
    .exp_i(exp_i), .frac_i(frac_i), .tag_o(tag_o), .exp_o(exp_o), .frac_o(frac_o), .top_o(top_o));

  task automatic drive(input logic [2:0] c, input logic [2:0] o, input logic [1:0] t,
                       input logic [15:0] e, input logic [63:0] f, input string req);
    logic [2:0] ra, wa;
    exp_t x;
    @(negedge clk);
    cmd = c; ofs = o; tag_i = t; exp_i = e; frac_i = f;
    ra = (c == 3'd3) ? 3'(mtop + o) : mtop;
    x.tag = mt[ra]; x.ex = me[ra]; x.fr = mf[ra]; x.top = mtop; x.req = req;
    sb.push_back(x);
    if (c == 3'd1) begin mtop = mtop - 3'd1; mt[mtop] = t; me[mtop] = e; mf[mtop] = f; end
    else if (c == 3'd2) mtop = mtop + 3'd1;
    else if (c == 3'd4) begin wa = 3'(mtop + o); mt[wa] = t; me[wa] = e; mf[wa] = f; end
  endtask

  always @(negedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      compared++;
      if (tag_o !== x.tag || exp_o !== x.ex || frac_o !== x.fr || top_o !== x.top) begin
        mismatched++;
        $display("FAIL %s: got tag=%h exp=%h frac=%h top=%0d expected tag=%h exp=%h frac=%h top=%0d",
          x.req, tag_o, exp_o, frac_o, top_o, x.tag, x.ex, x.fr, x.top);
      end
    end
  end

  function automatic logic [63:0] pat(input int k);
    return {32'hA5C3_0000 | 32'(k), ~32'(k * 7919)};
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin mt[i] = 2'b11; me[i] = 0; mf[i] = 0; end
    mtop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state seen through every offset
    for (int i = 0; i < 8; i++) drive(3'd3, 3'(i), 0, 0, 0, "R1");
    // R3 R7 R9: nine pushes, wrap through zero
    for (int k = 0; k < 9; k++) begin
      drive(3'd1, 0, 2'(k), 16'(16'h8000 ^ (k * 257)), pat(k), "R3");
      drive(3'd0, 0, 0, 0, 0, "R8");
    end
    // R5: sweep offsets
    for (int i = 0; i < 8; i++) drive(3'd3, 3'(i), 0, 0, 0, "R5");
    // R4: pops with reads
    for (int k = 0; k < 3; k++) drive(3'd2, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 8; i++) drive(3'd3, 3'(i), 0, 0, 0, "R5");
    // R6: offset write then neighbour reads
    drive(3'd4, 3'd5, 2'b01, 16'h7FFF, 64'hDEAD_BEEF_0123_4567, "R6");
    for (int i = 0; i < 8; i++) drive(3'd3, 3'(i), 0, 0, 0, "R6");
    // R2: unused codes act idle
    drive(3'd5, 3'd2, 2'b10, 16'h1111, 64'h1, "R2");
    drive(3'd6, 3'd3, 2'b10, 16'h2222, 64'h2, "R2");
    drive(3'd7, 3'd4, 2'b10, 16'h3333, 64'h3, "R2");
    for (int i = 0; i < 8; i++) drive(3'd3, 3'(i), 0, 0, 0, "R2");
    // R7: bring pointer to 2, offset 7 -> slot 1; pop through 7 -> 0
    while (mtop != 3'd2) drive(3'd2, 0, 0, 0, 0, "R7");
    drive(3'd3, 3'd7, 0, 0, 0, "R7");
    drive(3'd4, 3'd7, 2'b00, 16'h0001, 64'hFFFF_0000_FFFF_0000, "R7");
    drive(3'd3, 3'd7, 0, 0, 0, "R7");
    while (mtop != 3'd7) drive(3'd1, 0, 2'b10, 16'h00F0, 64'h0F, "R7");
    drive(3'd2, 0, 0, 0, 0, "R7");
    drive(3'd0, 0, 0, 0, 0, "R7");
    // R9: independent field patterns
    drive(3'd1, 0, 2'b01, 16'hFFFF, 64'h0, "R9");
    drive(3'd1, 0, 2'b10, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    drive(3'd3, 3'd1, 0, 0, 0, "R9");
    drive(3'd0, 0, 0, 0, 0, "R9");
    // R1: reset again
    @(negedge clk); cmd = 0; rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 8; i++) mt[i] = 2'b11;
    for (int i = 0; i < 8; i++) begin me[i] = 0; mf[i] = 0; end
    mtop = 0;
    for (int i = 0; i < 8; i++) drive(3'd3, 3'(i), 0, 0, 0, "R1");
    drive(3'd0, 0, 0, 0, 0, "R1");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule